// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Wireless Gating

This block decides which requester may use a shared non-volatile memory: a wired two-wire (I2C) target or a wireless command receiver. It keeps one of three states. The Internal state covers start-up, memory programming and the transmission of wireless replies. The Host state gives the memory to the wired target. The Idle state doubles as the wireless receive state, and in it the wireless side is granted whenever at least one of its antenna ports is enabled.

The block also produces one enable per wireless port. A kill control removes every port. Next, a debounced DC-supply presence signal removes every port unless a DC-wireless enable bit allows it. Last, a disable bit per port removes that port alone. When the wireless side programs the memory while the host supply is absent and the wake bit is set, the block pulls the clock line low for the whole write so that a sleeping host notices.

Top module: `nvm_port_arbiter`

## Requirements
- R1: After reset the block is in the Internal state (`gnt_internal`=1, `gnt_i2c`=0, `gnt_rf`=0, `scl_pull_low`=0). At most one of the three grant outputs is high in any cycle.
- R2: In the Internal state, `i2c_addr_match` and `rf_cmd_done` have no effect. The state ends only on `int_done`, and the next state is Idle.
- R3: In Idle, `i2c_addr_match` moves the block to the Host state (`gnt_i2c`=1) on the next cycle. It wins over an `rf_cmd_done` in the same cycle.
- R4: In the Host state, `rf_cmd_done` is ignored. The state is held for any number of cycles, with no timeout, until `i2c_stop` or `i2c_start_nomatch`.
- R5: When the Host state ends, the next state is Internal if `i2c_wr_req` was seen at any point in that transaction, including the ending cycle. Otherwise the next state is Idle.
- R6: In Idle, `gnt_rf` equals the OR of `rf_port_en`. An `rf_cmd_done` moves the block to Internal only when that OR is 1; otherwise it is ignored.
- R7: `cfg_kill`=1 forces every bit of `rf_port_en` to 0, whatever the other controls are.
- R8: With DC debounced as present and `cfg_dc_rf_en`=0, every bit of `rf_port_en` is 0. With `cfg_dc_rf_en`=1, or with DC absent, the per-port bits decide.
- R9: `cfg_port_dis[i]`=1 clears `rf_port_en[i]` only. Bit 0 is port 0 and bit 1 is port 1.
- R10: `dc_present_raw` passes a two-flop synchronizer. A change is taken only after it has held for `DEB_CYCLES` (default 8) clocks. Shorter pulses are ignored.
- R11: `scl_pull_low` is 1 exactly when all of these hold: the block is in an Internal state entered by an `rf_cmd_done` with `rf_cmd_is_write`=1, `cfg_wake_en`=1, DC is debounced as absent, and `nvm_wr_busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i2c_addr_match | input | 1 | Strobe: the wired target saw its own device address |
| i2c_stop | input | 1 | Strobe: STOP seen on the bus |
| i2c_start_nomatch | input | 1 | Strobe: START carrying a foreign address |
| i2c_wr_req | input | 1 | Strobe: a valid memory write was requested in this transaction |
| rf_cmd_done | input | 1 | Strobe: a wireless command was fully received |
| rf_cmd_is_write | input | 1 | Qualifies rf_cmd_done: the command programs the memory |
| int_done | input | 1 | Strobe: internal work (init, write, reply) finished |
| nvm_wr_busy | input | 1 | Memory programming in progress |
| dc_present_raw | input | 1 | Asynchronous DC supply presence |
| cfg_kill | input | 1 | Kill: all wireless ports off |
| cfg_dc_rf_en | input | 1 | Allow wireless operation while DC is present |
| cfg_port_dis | input | NUM_RF_PORTS | Per-port wireless disable |
| cfg_wake_en | input | 1 | Enable clock-line wake on wireless writes |
| gnt_internal | output | 1 | Memory held by the internal sequencer |
| gnt_i2c | output | 1 | Memory granted to the wired target |
| gnt_rf | output | 1 | Memory available to the wireless receiver |
| rf_port_en | output | NUM_RF_PORTS | Wireless port enables |
| scl_pull_low | output | 1 | Drive the clock line low (wake the host) |

## Verification
A wrong state register shows up one cycle after the triggering strobe as a wrong grant pattern. Examples are a host grant that fails to appear after an address match, or an Internal grant that survives a STOP when no write was requested. A lost write-pending flag or write-origin flag shows up only when the transaction ends or during programming, as a wrong next state or a wrong clock-line pull. A fault in the debouncer shows up as port enables that switch on a glitch, or that fail to switch within `DEB_CYCLES` plus two clocks after a held change.

// File: rtl/nvm_arb_pkg.sv
package nvm_arb_pkg;
    typedef enum logic [1:0] {
        ST_INTERNAL = 2'd0,
        ST_HOST     = 2'd1,
        ST_IDLE     = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dc_debounce.sv
module dc_debounce #(
    parameter int DEB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_out
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t d, q;

    always_comb begin
        d    = q;
        d.s1 = raw_in;
        d.s2 = q.s1;
        if (q.s2 != q.lvl) begin
            if (q.cnt == CW'(DEB_CYCLES - 1)) begin
                d.lvl = q.s2;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_out = q.lvl;

    AST_DEB_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lvl != $past(q.lvl)) |-> (q.lvl == $past(q.s2))); // R10
endmodule

// File: rtl/rf_gate.sv
module rf_gate #(
    parameter int NUM_PORTS = 2
) (
    input  logic                 kill,
    input  logic                 dc_ok,
    input  logic                 dc_rf_en,
    input  logic [NUM_PORTS-1:0] port_dis,
    output logic [NUM_PORTS-1:0] port_en
);
    logic global_ok;

    always_comb begin
        global_ok = 1'b1;
        if (kill)                     global_ok = 1'b0;
        else if (dc_ok && !dc_rf_en)  global_ok = 1'b0;
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        assign port_en[i] = global_ok & ~port_dis[i];
    end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import nvm_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic i2c_addr_match,
    input  logic i2c_stop,
    input  logic i2c_start_nomatch,
    input  logic i2c_wr_req,
    input  logic rf_cmd_done,
    input  logic rf_cmd_is_write,
    input  logic int_done,
    input  logic rf_any_en,
    output logic gnt_internal,
    output logic gnt_i2c,
    output logic gnt_rf,
    output logic rf_write_q
);
    typedef struct packed {
        arb_state_e state;
        logic       wr_pend;
        logic       rf_wr;
    } fsm_t;

    fsm_t d, q;
    logic host_end;

    assign host_end = i2c_stop | i2c_start_nomatch;

    always_comb begin
        d = q;
        case (q.state)
            ST_INTERNAL: begin
                if (int_done) begin
                    d.state = ST_IDLE;
                    d.rf_wr = 1'b0;
                end
            end
            ST_IDLE: begin
                if (i2c_addr_match) begin
                    d.state   = ST_HOST;
                    d.wr_pend = 1'b0;
                end else if (rf_cmd_done && rf_any_en) begin
                    d.state = ST_INTERNAL;
                    d.rf_wr = rf_cmd_is_write;
                end
            end
            ST_HOST: begin
                if (i2c_wr_req) d.wr_pend = 1'b1;
                if (host_end) begin
                    d.state   = (q.wr_pend || i2c_wr_req) ? ST_INTERNAL : ST_IDLE;
                    d.wr_pend = 1'b0;
                    d.rf_wr   = 1'b0;
                end
            end
            default: d.state = ST_INTERNAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_INTERNAL;
            q.wr_pend <= 1'b0;
            q.rf_wr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign gnt_internal = (q.state == ST_INTERNAL);
    assign gnt_i2c      = (q.state == ST_HOST);
    assign gnt_rf       = (q.state == ST_IDLE) && rf_any_en;
    assign rf_write_q   = q.rf_wr;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_internal, gnt_i2c, gnt_rf})); // R1
    AST_INTERNAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_internal && !int_done) |=> gnt_internal); // R2
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_IDLE) && i2c_addr_match) |=> gnt_i2c); // R3
    AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i2c && !host_end) |=> gnt_i2c); // R4
    AST_HOST_WRITE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i2c && host_end && (q.wr_pend || i2c_wr_req)) |=> gnt_internal); // R5
    AST_RF_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_IDLE) && !rf_any_en && !i2c_addr_match) |=> (q.state == ST_IDLE)); // R6
endmodule

// File: rtl/nvm_port_arbiter.sv
module nvm_port_arbiter #(
    parameter int NUM_RF_PORTS = 2,
    parameter int DEB_CYCLES   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i2c_addr_match,
    input  logic                    i2c_stop,
    input  logic                    i2c_start_nomatch,
    input  logic                    i2c_wr_req,
    input  logic                    rf_cmd_done,
    input  logic                    rf_cmd_is_write,
    input  logic                    int_done,
    input  logic                    nvm_wr_busy,
    input  logic                    dc_present_raw,
    input  logic                    cfg_kill,
    input  logic                    cfg_dc_rf_en,
    input  logic [NUM_RF_PORTS-1:0] cfg_port_dis,
    input  logic                    cfg_wake_en,
    output logic                    gnt_internal,
    output logic                    gnt_i2c,
    output logic                    gnt_rf,
    output logic [NUM_RF_PORTS-1:0] rf_port_en,
    output logic                    scl_pull_low
);
    logic dc_ok;
    logic rf_write_q;
    logic rf_any_en;

    dc_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (dc_present_raw),
        .level_out (dc_ok)
    );

    rf_gate #(.NUM_PORTS(NUM_RF_PORTS)) u_gate (
        .kill     (cfg_kill),
        .dc_ok    (dc_ok),
        .dc_rf_en (cfg_dc_rf_en),
        .port_dis (cfg_port_dis),
        .port_en  (rf_port_en)
    );

    assign rf_any_en = |rf_port_en;

    arb_fsm u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .i2c_addr_match    (i2c_addr_match),
        .i2c_stop          (i2c_stop),
        .i2c_start_nomatch (i2c_start_nomatch),
        .i2c_wr_req        (i2c_wr_req),
        .rf_cmd_done       (rf_cmd_done),
        .rf_cmd_is_write   (rf_cmd_is_write),
        .int_done          (int_done),
        .rf_any_en         (rf_any_en),
        .gnt_internal      (gnt_internal),
        .gnt_i2c           (gnt_i2c),
        .gnt_rf            (gnt_rf),
        .rf_write_q        (rf_write_q)
    );

    assign scl_pull_low = gnt_internal & rf_write_q & cfg_wake_en & ~dc_ok & nvm_wr_busy;

    AST_KILL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_kill |-> (rf_port_en == '0)); // R7
    AST_DC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_ok && !cfg_dc_rf_en) |-> (rf_port_en == '0)); // R8
    AST_WAKE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_low |-> (gnt_internal && nvm_wr_busy && !dc_ok)); // R11
endmodule

// File: tb/nvm_port_arbiter_tb.sv
module nvm_port_arbiter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i2c_addr_match = 0, i2c_stop = 0, i2c_start_nomatch = 0, i2c_wr_req = 0;
    logic rf_cmd_done = 0, rf_cmd_is_write = 0, int_done = 0, nvm_wr_busy = 0;
    logic dc_present_raw = 0, cfg_kill = 0, cfg_dc_rf_en = 0, cfg_wake_en = 0;
    logic [1:0] cfg_port_dis = 2'b00;
    logic gnt_internal, gnt_i2c, gnt_rf, scl_pull_low;
    logic [1:0] rf_port_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nvm_port_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .i2c_addr_match(i2c_addr_match), .i2c_stop(i2c_stop),
        .i2c_start_nomatch(i2c_start_nomatch), .i2c_wr_req(i2c_wr_req),
        .rf_cmd_done(rf_cmd_done), .rf_cmd_is_write(rf_cmd_is_write),
        .int_done(int_done), .nvm_wr_busy(nvm_wr_busy),
        .dc_present_raw(dc_present_raw), .cfg_kill(cfg_kill),
        .cfg_dc_rf_en(cfg_dc_rf_en), .cfg_port_dis(cfg_port_dis),
        .cfg_wake_en(cfg_wake_en),
        .gnt_internal(gnt_internal), .gnt_i2c(gnt_i2c), .gnt_rf(gnt_rf),
        .rf_port_en(rf_port_en), .scl_pull_low(scl_pull_low)
    );

    function automatic logic [1:0] exp_en(logic kill, logic dc, logic dcen, logic [1:0] dis);
        if (kill) return 2'b00;
        if (dc && !dcen) return 2'b00;
        return ~dis;
    endfunction

    // grants packed as {internal, i2c, rf}
    function automatic logic [2:0] exp_gnt_idle(logic [1:0] en);
        return {1'b0, 1'b0, |en};
    endfunction

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gnts();
        return {5'b0, gnt_internal, gnt_i2c, gnt_rf};
    endfunction

    task automatic pulse_int_done();
        int_done = 1; tick(); int_done = 0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 reset grants", gnts(), 8'b100);
        chk("R1 reset scl", {7'b0, scl_pull_low}, 8'd0);

        // R2 Internal ignores both requesters
        i2c_addr_match = 1; tick(); i2c_addr_match = 0; tick();
        chk("R2 addr match ignored", gnts(), 8'b100);
        rf_cmd_done = 1; tick(); rf_cmd_done = 0; tick();
        chk("R2 rf cmd ignored", gnts(), 8'b100);
        pulse_int_done();
        chk("R2 int_done to idle", gnts(), {5'b0, exp_gnt_idle(2'b11)});

        // R3 host priority over simultaneous rf command
        i2c_addr_match = 1; rf_cmd_done = 1; tick();
        i2c_addr_match = 0; rf_cmd_done = 0;
        chk("R3 host wins", gnts(), 8'b010);

        // R4 rf ignored and no timeout in host state
        rf_cmd_done = 1; tick(); rf_cmd_done = 0;
        tick(60);
        chk("R4 host held", gnts(), 8'b010);

        // R5 stop without write -> idle
        i2c_stop = 1; tick(); i2c_stop = 0;
        chk("R5 stop no write", gnts(), 8'b001);
        // R5 write earlier in transaction then stop -> internal
        i2c_addr_match = 1; tick(); i2c_addr_match = 0;
        i2c_wr_req = 1; tick(); i2c_wr_req = 0; tick(3);
        chk("R5 write pending kept", gnts(), 8'b010);
        i2c_stop = 1; tick(); i2c_stop = 0;
        chk("R5 stop with write", gnts(), 8'b100);
        pulse_int_done();
        // R5 write on ending cycle, foreign start
        i2c_addr_match = 1; tick(); i2c_addr_match = 0;
        i2c_start_nomatch = 1; i2c_wr_req = 1; tick();
        i2c_start_nomatch = 0; i2c_wr_req = 0;
        chk("R5 foreign start with write", gnts(), 8'b100);
        pulse_int_done();
        // R5 pending flag cleared for next transaction
        i2c_addr_match = 1; tick(); i2c_addr_match = 0;
        i2c_start_nomatch = 1; tick(); i2c_start_nomatch = 0;
        chk("R5 foreign start no write", gnts(), 8'b001);

        // R6 rf command accepted / blocked
        rf_cmd_done = 1; tick(); rf_cmd_done = 0;
        chk("R6 rf cmd to internal", gnts(), 8'b100);
        pulse_int_done();
        cfg_port_dis = 2'b11; tick();
        chk("R6 gnt_rf low when ports off", gnts(), 8'b000);
        rf_cmd_done = 1; tick(); rf_cmd_done = 0;
        chk("R6 rf cmd ignored when ports off", gnts(), 8'b000);
        cfg_port_dis = 2'b01; tick();
        chk("R9 port1 only", {6'b0, rf_port_en}, 8'b10);
        cfg_port_dis = 2'b00; tick();

        // R11 wake pull
        cfg_wake_en = 1; rf_cmd_is_write = 1;
        rf_cmd_done = 1; tick(); rf_cmd_done = 0; rf_cmd_is_write = 0;
        chk("R11 no pull before busy", {7'b0, scl_pull_low}, 8'd0);
        nvm_wr_busy = 1; tick(5);
        chk("R11 pull during write", {7'b0, scl_pull_low}, 8'd1);
        nvm_wr_busy = 0; tick();
        chk("R11 release after write", {7'b0, scl_pull_low}, 8'd0);
        pulse_int_done();
        rf_cmd_done = 1; tick(); rf_cmd_done = 0; nvm_wr_busy = 1; tick();
        chk("R11 no pull for rf read", {7'b0, scl_pull_low}, 8'd0);
        nvm_wr_busy = 0; pulse_int_done();
        cfg_wake_en = 0; rf_cmd_is_write = 1;
        rf_cmd_done = 1; tick(); rf_cmd_done = 0; rf_cmd_is_write = 0; nvm_wr_busy = 1; tick();
        chk("R11 no pull when wake off", {7'b0, scl_pull_low}, 8'd0);
        nvm_wr_busy = 0; pulse_int_done();
        i2c_addr_match = 1; tick(); i2c_addr_match = 0; i2c_wr_req = 1; tick(); i2c_wr_req = 0;
        i2c_stop = 1; cfg_wake_en = 1; tick(); i2c_stop = 0; nvm_wr_busy = 1; tick();
        chk("R11 no pull for host write", {7'b0, scl_pull_low}, 8'd0);
        nvm_wr_busy = 0; pulse_int_done();

        // R10 debounce: short glitch ignored, held level taken
        dc_present_raw = 1; tick(4); dc_present_raw = 0; tick(20);
        chk("R10 glitch ignored", {6'b0, rf_port_en}, 8'b11);
        dc_present_raw = 1; tick(20);
        chk("R8 dc present disables", {6'b0, rf_port_en}, 8'b00);
        cfg_wake_en = 1; cfg_dc_rf_en = 1; tick();
        chk("R8 dc rf enable restores", {6'b0, rf_port_en}, 8'b11);
        rf_cmd_is_write = 1; rf_cmd_done = 1; tick(); rf_cmd_done = 0; rf_cmd_is_write = 0;
        nvm_wr_busy = 1; tick();
        chk("R11 no pull with dc present", {7'b0, scl_pull_low}, 8'd0);
        nvm_wr_busy = 0; pulse_int_done();
        cfg_dc_rf_en = 0; dc_present_raw = 0; tick(20);
        chk("R10 dc removal taken", {6'b0, rf_port_en}, 8'b11);

        // R7 R8 R9 random gating
        for (int i = 0; i < 60; i++) begin
            logic k, dc, de;
            logic [1:0] ds;
            k  = ($urandom % 4) == 0;
            dc = $urandom % 2;
            de = $urandom % 2;
            ds = 2'($urandom % 4);
            cfg_kill = k; dc_present_raw = dc; cfg_dc_rf_en = de; cfg_port_dis = ds;
            tick(DEB_WAIT);
            chk(k ? "R7 kill gating" : (dc ? "R8 dc gating" : "R9 port gating"),
                {6'b0, rf_port_en}, {6'b0, exp_en(k, dc, de, ds)});
            chk("R6 idle grant follows ports", gnts(), {5'b0, exp_gnt_idle(exp_en(k, dc, de, ds))});
        end
        cfg_kill = 1; cfg_dc_rf_en = 1; dc_present_raw = 0; cfg_port_dis = 2'b00; tick();
        chk("R7 kill overrides all", {6'b0, rf_port_en}, 8'b00);
        cfg_kill = 0; tick();
        chk("R7 kill cleared restores", {6'b0, rf_port_en}, 8'b11);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    localparam int DEB_WAIT = 16;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule